// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a register-mapped controller for thirty-two general-purpose lines. The lines form four ports of eight pins each. A simple 32-bit register bus with byte-lane enables reaches six registers:

- a per-line alternate-function select;
- a per-line direction;
- a data register that writes the output latch and reads back the line value;
- a per-line pending-edge status;
- two words of two-bit trigger fields.

Each input passes through a two-flop synchroniser. A rising edge, a falling edge or either edge then latches a status flag. Software clears a flag by writing one to it. A single interrupt output is the OR of every pending flag.

Line L belongs to port L/8 and is pin L%8 of that port. The one-bit-per-line registers hold one byte per port in big-endian order, so port 0 sits in the top byte of the word. The trigger fields use one 16-bit half per port. The lower address of each half is the more significant half of its word.

Top module: `gpio_edge_bank`

## Requirements
- R1: A synchronous active-high reset clears every register and every pending flag. It drives `irq`, `pin_oe`, `pin_out` and `pin_alt` low.
- R2: Byte offsets on `bus_addr` are decoded as follows, with `bus_addr[1:0]` ignored:
  - 0x00: select
  - 0x08: direction
  - 0x0C: data
  - 0x10: status
  - 0x14: trigger fields for ports 0 and 1
  - 0x18: trigger fields for ports 2 and 3

  Any other offset (0x04, 0x1C) reads zero, and writes to it change nothing.
- R3: In every one-bit-per-line register, line L sits at word bit (3 - L/8)*8 + L%8. `bus_be[k]` gates the write of bits 8k+7:8k, and bits in a disabled lane keep their value.
- R4: Direction bit 1 makes the line an output: `pin_oe` goes high and `pin_out` carries the data latch. Direction bit 0 makes it an input. A write to offset 0x0C loads the latch.
- R5: Reading offset 0x0C returns the latch for output lines. For input lines it returns the pin value after two flop stages, so a change first shows after the second rising clock edge.
- R6: The select register drives `pin_alt` per line (1 = dedicated peripheral function) and has no effect on any other output.
- R7: Each line has a two-bit trigger code: 00 off, 01 falling, 10 rising, 11 both. The field for port p, pin n lies at bits 2n+1:2n of the 16-bit half at offset 0x14+2p. An even p uses bits 31:16 of its word, and an odd p uses bits 15:0.
- R8: A status flag sets only on an edge that matches its trigger code. It is readable after the third rising clock edge following the pin change. Code 00 never sets a flag.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it as it was. If an edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is high exactly while at least one status flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the bank |
| bus_be | input | 4 | Byte-lane write enables, bit k for bits 8k+7:8k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Line inputs, indexed by line number |
| pin_out | output | 32 | Output latch per line |
| pin_oe | output | 32 | Output enable per line |
| pin_alt | output | 32 | Alternate-function select per line |
| irq | output | 1 | Combined interrupt |

## Verification
Edge detection is exercised in four ways:

- Single rising and falling pulses on lines configured for rising-only, falling-only, both, and off. These separate a correct trigger decode from a swapped one or one that ignores the code.
- Lines picked from different ports. These expose an error in the byte order or the half order.
- A clear written in the very cycle an edge lands. This decides the set-over-clear priority.
- Clears written with single-lane byte enables or with zero data. These tell apart masked clears from blanket ones.

Register round-trips through a stimulus table, together with reads of the data register while the pins and directions are mixed, separate the latch path from the synchronised input path.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PORTS          = 4;
    localparam int PINS_PER_PORT  = 8;
    localparam int LINES          = PORTS * PINS_PER_PORT;
    localparam int BUS_W          = 32;
    localparam int LANES          = BUS_W / 8;
    localparam int ADDR_W         = 5;
    localparam int TRIG_W         = 2;
    localparam int HALF_W         = PINS_PER_PORT * TRIG_W;
    localparam int PORTS_PER_TRIG = BUS_W / HALF_W;

    typedef logic [LINES-1:0]        line_vec_t;
    typedef logic [BUS_W-1:0]        word_t;
    typedef logic [LINES*TRIG_W-1:0] trig_vec_t;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_e;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SEL,
        REG_DIR,
        REG_DATA,
        REG_STAT,
        REG_TRIG0,
        REG_TRIG1
    } reg_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    localparam logic [ADDR_W-1:0] OFS_SEL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_TRIG0 = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_TRIG1 = 5'h18;

    // Word bit that carries line l in the one-bit-per-line registers.
    // Port 0 occupies the most significant byte.
    function automatic int line_bit(input int l);
        return (PORTS - 1 - l / PINS_PER_PORT) * PINS_PER_PORT + l % PINS_PER_PORT;
    endfunction

    function automatic word_t lines_to_word(input line_vec_t v);
        word_t w;
        w = '0;
        for (int l = 0; l < LINES; l++) begin
            w[line_bit(l)] = v[l];
        end
        return w;
    endfunction

    function automatic line_vec_t word_to_lines(input word_t w);
        line_vec_t v;
        v = '0;
        for (int l = 0; l < LINES; l++) begin
            v[l] = w[line_bit(l)];
        end
        return v;
    endfunction

    function automatic word_t lane_mask(input logic [LANES-1:0] be);
        word_t w;
        for (int k = 0; k < LANES; k++) begin
            w[k*8 +: 8] = {8{be[k]}};
        end
        return w;
    endfunction

    // Which trigger word holds line l.
    function automatic int trig_word(input int l);
        return (l / PINS_PER_PORT) / PORTS_PER_TRIG;
    endfunction

    // Lowest bit of line l's field inside its trigger word.
    // Even ports take the upper half.
    function automatic int trig_bit(input int l);
        int p;
        p = l / PINS_PER_PORT;
        return (PORTS_PER_TRIG - 1 - p % PORTS_PER_TRIG) * HALF_W + (l % PINS_PER_PORT) * TRIG_W;
    endfunction

    function automatic word_t trig_to_word(input trig_vec_t t, input int widx);
        word_t w;
        w = '0;
        for (int l = 0; l < LINES; l++) begin
            if (trig_word(l) == widx) begin
                w[trig_bit(l) +: TRIG_W] = t[l*TRIG_W +: TRIG_W];
            end
        end
        return w;
    endfunction

    function automatic trig_vec_t trig_merge(input trig_vec_t old, input word_t wd,
                                             input word_t m, input int widx);
        trig_vec_t t;
        t = old;
        for (int l = 0; l < LINES; l++) begin
            if (trig_word(l) == widx) begin
                for (int b = 0; b < TRIG_W; b++) begin
                    if (m[trig_bit(l) + b]) begin
                        t[l*TRIG_W + b] = wd[trig_bit(l) + b];
                    end
                end
            end
        end
        return t;
    endfunction

    function automatic reg_e decode(input logic [ADDR_W-1:0] addr);
        logic [ADDR_W-1:0] a;
        a = {addr[ADDR_W-1:2], 2'b00};
        case (a)
            OFS_SEL:   return REG_SEL;
            OFS_DIR:   return REG_DIR;
            OFS_DATA:  return REG_DATA;
            OFS_STAT:  return REG_STAT;
            OFS_TRIG0: return REG_TRIG0;
            OFS_TRIG1: return REG_TRIG1;
            default:   return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] since_rst;
            always_ff @(posedge clk) begin
                if (rst) since_rst <= '0;
                else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
            end
            // R5: the synchronised value trails the pin by two edges
            assert_sync_latency_R5: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd2) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
    import gpio_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t sync_in,
    input  trig_vec_t trig,
    input  line_vec_t clr,
    output line_vec_t status
);

    line_vec_t prev;
    line_vec_t hit;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= sync_in;
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            trig_e tc;
            edge_t ev;

            assign tc      = trig_e'(trig[g*TRIG_W +: TRIG_W]);
            assign ev.rise = sync_in[g] & ~prev[g];
            assign ev.fall = ~sync_in[g] & prev[g];
            assign hit[g]  = (ev.rise && (tc == TRIG_RISE || tc == TRIG_BOTH)) ||
                             (ev.fall && (tc == TRIG_FALL || tc == TRIG_BOTH));

            always_ff @(posedge clk) begin
                if (rst)         status[g] <= 1'b0;
                else if (hit[g]) status[g] <= 1'b1;
                else if (clr[g]) status[g] <= 1'b0;
            end

            // R9: a clear with no competing edge drops the flag
            assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (rst)
                (clr[g] && !hit[g]) |=> !status[g]);
            // R8: a disabled line never raises its flag
            assert_off_never_sets_R8: assert property (@(posedge clk) disable iff (rst)
                $rose(status[g]) |-> ($past(tc) != TRIG_OFF));
        end
    endgenerate

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  word_t             bus_wdata,
    output word_t             bus_rdata,
    input  line_vec_t         sync_in,
    input  line_vec_t         status,
    output line_vec_t         sel_q,
    output line_vec_t         dir_q,
    output line_vec_t         out_q,
    output trig_vec_t         trig_q,
    output line_vec_t         clr_mask
);

    reg_e      target;
    logic      wr_en;
    word_t     wmask;
    line_vec_t lmask;
    line_vec_t ldata;
    line_vec_t data_view;

    assign target = decode(bus_addr);
    assign wr_en  = bus_sel & bus_wr;
    assign wmask  = lane_mask(bus_be);
    assign lmask  = word_to_lines(wmask);
    assign ldata  = word_to_lines(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            dir_q  <= '0;
            out_q  <= '0;
            trig_q <= '0;
        end else if (wr_en) begin
            case (target)
                REG_SEL:   sel_q  <= (sel_q & ~lmask) | (ldata & lmask);
                REG_DIR:   dir_q  <= (dir_q & ~lmask) | (ldata & lmask);
                REG_DATA:  out_q  <= (out_q & ~lmask) | (ldata & lmask);
                REG_TRIG0: trig_q <= trig_merge(trig_q, bus_wdata, wmask, 0);
                REG_TRIG1: trig_q <= trig_merge(trig_q, bus_wdata, wmask, 1);
                default:   ;
            endcase
        end
    end

    assign clr_mask  = (wr_en && target == REG_STAT) ? (ldata & lmask) : '0;
    assign data_view = (dir_q & out_q) | (~dir_q & sync_in);

    always_comb begin
        case (target)
            REG_SEL:   bus_rdata = lines_to_word(sel_q);
            REG_DIR:   bus_rdata = lines_to_word(dir_q);
            REG_DATA:  bus_rdata = lines_to_word(data_view);
            REG_STAT:  bus_rdata = lines_to_word(status);
            REG_TRIG0: bus_rdata = trig_to_word(trig_q, 0);
            REG_TRIG1: bus_rdata = trig_to_word(trig_q, 1);
            default:   bus_rdata = '0;
        endcase
    end

    // R4: direction holds unless it is written
    assert_dir_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && target == REG_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic [LINES-1:0]  pin_alt,
    output logic              irq
);

    line_vec_t sync_val;
    line_vec_t status;
    line_vec_t clr_mask;
    line_vec_t sel_q;
    line_vec_t dir_q;
    line_vec_t out_q;
    trig_vec_t trig_q;

    gpio_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (sync_val)
    );

    gpio_bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_val),
        .status    (status),
        .sel_q     (sel_q),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .trig_q    (trig_q),
        .clr_mask  (clr_mask)
    );

    gpio_edge_status u_edges (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_val),
        .trig    (trig_q),
        .clr     (clr_mask),
        .status  (status)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign pin_alt = sel_q;
    assign irq     = |status;

    // R10: the interrupt only drops after a status clear
    assert_irq_drop_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(|clr_mask));

endmodule

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;

    typedef struct packed {
        logic [4:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        vec_t'{5'h00, 4'hF,    32'hA5A5_5A5A, 32'hA5A5_5A5A},
        vec_t'{5'h08, 4'b0001, 32'hFFFF_FFFF, 32'h0000_00FF},
        vec_t'{5'h14, 4'hF,    32'h1234_5678, 32'h1234_5678},
        vec_t'{5'h18, 4'b1100, 32'hFFFF_FFFF, 32'hFFFF_0000},
        vec_t'{5'h04, 4'hF,    32'hFFFF_FFFF, 32'h0000_0000},
        vec_t'{5'h1C, 4'hF,    32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] pin_alt;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_bank u_gpio_edge_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_alt   (pin_alt),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Call at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        pin_in = '0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        logic [31:0] d;

        // R1 reset state
        do_reset();
        rd(5'h00, d); chk("R1 sel", d, 32'h0);
        rd(5'h08, d); chk("R1 dir", d, 32'h0);
        rd(5'h0C, d); chk("R1 data", d, 32'h0);
        rd(5'h10, d); chk("R1 status", d, 32'h0);
        rd(5'h14, d); chk("R1 trig0", d, 32'h0);
        rd(5'h18, d); chk("R1 trig1", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 oe", pin_oe, 32'h0);

        // R2 R3 R7 register table
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].addr, VECS[i].be, VECS[i].wdata);
            rd(VECS[i].addr, d);
            chk("R2/R3/R7 table", d, VECS[i].exp_rd);
        end

        // R4 R5 R6 direction, data, select
        do_reset();
        wr(5'h08, 4'hF, 32'hFF00_0000);
        wr(5'h0C, 4'hF, 32'h5A00_0000);
        chk("R4 oe", pin_oe, 32'h0000_00FF);
        chk("R4 out", pin_out, 32'h0000_005A);
        pin_in[7:0]   = 8'hFF;
        pin_in[31:24] = 8'h3C;
        wait_cycles(3);
        rd(5'h0C, d); chk("R5 mixed read", d, 32'h5A00_003C);
        pin_in[8] = 1'b1;
        @(negedge clk);
        rd(5'h0C, d); chk("R5 one edge", d, 32'h5A00_003C);
        @(negedge clk);
        rd(5'h0C, d); chk("R5 two edges", d, 32'h5A01_003C);
        wr(5'h0C, 4'b1000, 32'h1122_3344);
        chk("R3 lane data", pin_out, 32'h0000_0011);
        wr(5'h00, 4'hF, 32'h00C3_0081);
        chk("R6 alt", pin_alt, 32'h8100_C300);
        chk("R6 oe unchanged", pin_oe, 32'h0000_00FF);
        chk("R6 out unchanged", pin_out, 32'h0000_0011);

        // R7 R8 R9 R10 edges
        do_reset();
        wr(5'h14, 4'hF, 32'h0002_0004);
        wr(5'h18, 4'hF, 32'h0003_0000);
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(5'h10, d); chk("R8 latency two", d, 32'h0);
        @(negedge clk);
        rd(5'h10, d); chk("R8 rise line0", d, 32'h0100_0000);
        chk("R10 irq high", {31'h0, irq}, 32'h1);
        wr(5'h10, 4'hF, 32'h0100_0000);
        rd(5'h10, d); chk("R9 clear", d, 32'h0);
        chk("R10 irq low", {31'h0, irq}, 32'h0);
        pin_in[0] = 1'b0;
        wait_cycles(4);
        rd(5'h10, d); chk("R8 rise-only ignores fall", d, 32'h0);
        pin_in[9] = 1'b1;
        wait_cycles(4);
        rd(5'h10, d); chk("R8 fall-only ignores rise", d, 32'h0);
        pin_in[9] = 1'b0;
        wait_cycles(4);
        rd(5'h10, d); chk("R8 fall line9", d, 32'h0002_0000);
        pin_in[24] = 1'b1;
        wait_cycles(4);
        pin_in[24] = 1'b0;
        wait_cycles(4);
        rd(5'h10, d); chk("R8 code off", d, 32'h0002_0000);
        pin_in[16] = 1'b1;
        wait_cycles(4);
        rd(5'h10, d); chk("R7 both rise", d, 32'h0002_0100);
        wr(5'h10, 4'b0010, 32'h0002_0100);
        rd(5'h10, d); chk("R9 lane clear", d, 32'h0002_0000);
        pin_in[16] = 1'b0;
        wait_cycles(4);
        rd(5'h10, d); chk("R7 both fall", d, 32'h0002_0100);
        wr(5'h10, 4'hF, 32'h0);
        rd(5'h10, d); chk("R9 zero write", d, 32'h0002_0100);
        wr(5'h10, 4'hF, 32'hFFFF_FFFF);
        rd(5'h10, d); chk("R9 clear all", d, 32'h0);
        chk("R10 irq cleared", {31'h0, irq}, 32'h0);

        // R9 set beats clear in the same cycle
        pin_in[16] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(5'h10, 4'hF, 32'h0000_0100);
        rd(5'h10, d); chk("R9 set wins", d, 32'h0000_0100);
        chk("R10 irq after race", {31'h0, irq}, 32'h1);

        done = 1'b1;
        summary();
    end

endmodule